// File: doc/BRIEF.md
# Loop Lock and Range Status Reporter

This block reduces the health indications of a secondary oscillator loop to a single status value. That value is driven onto one external pin and can also be read by software as a status bit. A 2-bit mode selector picks what the value means. In lock mode it shows whether the loop is locked. In range mode it shows which side of its fine-tuning range the loop ran off when it last lost lock. The same pin and the same status bit serve both modes.

The lock and the two range indications come from the analog loop and are asynchronous, so each one first passes through a two-flop synchronizer. A loss of lock is a falling edge of the synchronized lock signal. At that edge a direction register captures the high-side indication. It holds that value until the next loss of lock. Losing the external reference also shows up as a loss of lock, because the loop is then pulled toward zero frequency.

The remaining inputs are configuration bits and are used as given. One of them enables the pin driver. Another disables the loop, which turns off the charge-pump enable output. The status outputs are combinational from the synchronized state, the direction register and the configuration bits.

Top module: `loop_status_reporter`

## Requirements
- R1: With `mode_sel` = 2'b00, `status_bit` is 1 while the synchronized lock input is 1 (locked) and 0 while it is 0 (unlocked). A lost external reference reads as unlocked.
- R2: With `mode_sel` = 2'b01, `status_bit` equals the direction register: 1 means out of range high, 0 means out of range low.
- R3: The direction register changes only on a 1-to-0 transition of the synchronized lock input. At that transition it loads 1 if the synchronized high indication is 1, and 0 otherwise. This holds whether the low indication is asserted or neither indication is. At all other times it keeps its value.
- R4: `status_pin_oe` is 1 only when `pin_en` is 1 and the mode is 2'b00 or 2'b01. While `status_pin_oe` is 0, `status_pin` is 0. While it is 1, `status_pin` equals `status_bit`. `status_bit` does not depend on `pin_en`.
- R5: `pump_en` is 0 whenever `loop_off` is 1, and 1 whenever `loop_off` is 0, in every mode.
- R6: With `mode_sel` = 2'b10 or 2'b11, `status_pin_oe` is 0 and `status_bit` is 0.
- R7: `lock_in`, `range_hi_in` and `range_lo_in` each pass through two flops. A change of `lock_in` that is present before a rising edge is not visible after that edge. It is visible after the following rising edge.
- R8: While `rst_n` is 0, and after it is released, the direction register is 0 and the lock status reads unlocked. This lasts until a locked indication has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Asynchronous lock indication, 1 = locked |
| range_hi_in | input | 1 | Asynchronous out-of-range-high indication |
| range_lo_in | input | 1 | Asynchronous out-of-range-low indication |
| mode_sel | input | 2 | Report mode: 00 lock, 01 range direction, 10/11 reserved |
| pin_en | input | 1 | Enables driving the status pin |
| loop_off | input | 1 | 1 disables the loop's charge pump |
| status_pin | output | 1 | Value for the external status pin |
| status_pin_oe | output | 1 | Output enable for the external status pin |
| status_bit | output | 1 | Software-readable status bit |
| pump_en | output | 1 | Charge-pump enable |

## Verification
A sequence of vectors drives the lock input through repeated loss-of-lock events. Across these events the high indication is asserted, the low indication is asserted, or neither is. This separates a register that captures at the falling edge from one that follows the range inputs or samples them at other times. Range inputs that change while lock stays constant or stays lost confirm that the direction holds. The pin enable, the loop-disable bit and the reserved mode codes are each toggled against a fixed status value, so that gating faults show up apart from reporting faults. Directed tests then cover the exact two-edge synchronizer latency and a reset taken while the direction register holds 1 and the loop is locked.

// File: rtl/loop_status_pkg.sv
package loop_status_pkg;
  typedef enum logic [1:0] {
    RPT_LOCK  = 2'b00,
    RPT_RANGE = 2'b01,
    RPT_RSV_A = 2'b10,
    RPT_RSV_B = 2'b11
  } rpt_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync
  import loop_status_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [SYNC_STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= din;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[SYNC_STAGES-1];

  // warm-up counter so the latency check never looks at pre-reset samples
  logic [1:0] warm_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  warm_cnt_q <= 2'd0;
    else if (warm_cnt_q != 2'd2) warm_cnt_q <= warm_cnt_q + 2'd1;
  end

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/lsr_dir_capture.sv
module lsr_dir_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic hi_s,
  input  logic lo_s,
  output logic dir_q,
  output logic lock_fall
);
  logic lock_prev_q;
  logic lo_unused;

  // the low indication only matters by being the "otherwise" case
  assign lo_unused = lo_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev_q <= 1'b0;
    else        lock_prev_q <= lock_s;
  end

  assign lock_fall = lock_prev_q & ~lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= 1'b0;
    else if (lock_fall) dir_q <= hi_s ? 1'b1 : 1'b0;
  end

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_fall |=> $stable(dir_q));

  // R3
  dir_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fall |=> (dir_q == $past(hi_s)));
endmodule

// File: rtl/lsr_output_gate.sv
module lsr_output_gate
  import loop_status_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       lock_s,
  input  logic       dir_q,
  input  logic       pin_en,
  input  logic       loop_off,
  output logic       status_pin,
  output logic       status_pin_oe,
  output logic       status_bit,
  output logic       pump_en
);
  rpt_mode_e mode;
  logic      mode_valid;
  logic      rpt_val;

  assign mode = rpt_mode_e'(mode_sel);

  always_comb begin
    rpt_val    = 1'b0;
    mode_valid = 1'b0;
    case (mode)
      RPT_LOCK:  begin rpt_val = lock_s; mode_valid = 1'b1; end
      RPT_RANGE: begin rpt_val = dir_q;  mode_valid = 1'b1; end
      default:   begin rpt_val = 1'b0;   mode_valid = 1'b0; end
    endcase
  end

  assign status_bit    = rpt_val;
  assign status_pin_oe = pin_en & mode_valid;
  assign status_pin    = status_pin_oe & rpt_val;
  assign pump_en       = ~loop_off;
endmodule

// File: rtl/loop_status_reporter.sv
module loop_status_reporter
  import loop_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_in,
  input  logic       range_hi_in,
  input  logic       range_lo_in,
  input  logic [1:0] mode_sel,
  input  logic       pin_en,
  input  logic       loop_off,
  output logic       status_pin,
  output logic       status_pin_oe,
  output logic       status_bit,
  output logic       pump_en
);
  localparam int unsigned N_ASYNC = 3;

  logic [N_ASYNC-1:0] raw_in;
  logic [N_ASYNC-1:0] synced;
  logic               lock_s, hi_s, lo_s;
  logic               dir_q, lock_fall;

  assign raw_in = {range_lo_in, range_hi_in, lock_in};

  lsr_sync #(.WIDTH(N_ASYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_in),
    .dout (synced)
  );

  assign lock_s = synced[0];
  assign hi_s   = synced[1];
  assign lo_s   = synced[2];

  lsr_dir_capture u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_s   (lock_s),
    .hi_s     (hi_s),
    .lo_s     (lo_s),
    .dir_q    (dir_q),
    .lock_fall(lock_fall)
  );

  lsr_output_gate u_gate (
    .mode_sel     (mode_sel),
    .lock_s       (lock_s),
    .dir_q        (dir_q),
    .pin_en       (pin_en),
    .loop_off     (loop_off),
    .status_pin   (status_pin),
    .status_pin_oe(status_pin_oe),
    .status_bit   (status_bit),
    .pump_en      (pump_en)
  );

  // R1
  lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (status_bit == lock_s));

  // R2
  range_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> (status_bit == dir_q));

  // R4
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_pin_oe |-> !status_pin);

  // R5
  pump_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_off |-> !pump_en);

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |-> (!status_pin_oe && !status_bit));
endmodule

// File: tb/loop_status_reporter_bench.sv
module loop_status_reporter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_in = 1'b0, range_hi_in = 1'b0, range_lo_in = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       pin_en = 1'b1, loop_off = 1'b0;
  logic       status_pin, status_pin_oe, status_bit, pump_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_status_reporter u_loop_status_reporter (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .range_hi_in(range_hi_in),
    .range_lo_in(range_lo_in), .mode_sel(mode_sel), .pin_en(pin_en),
    .loop_off(loop_off), .status_pin(status_pin), .status_pin_oe(status_pin_oe),
    .status_bit(status_bit), .pump_en(pump_en)
  );

  // {mode[1:0], pin_en, loop_off, lock, hi, lo, exp_pin, exp_oe, exp_bit, exp_pump}
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b00_1_0_100_1111, // R1 locked
    11'b01_1_0_110_0101, // R3 hi rises, no loss: hold 0
    11'b01_1_0_010_1111, // R3 loss with hi -> 1
    11'b01_1_0_001_1111, // R3 hold while unlocked
    11'b01_1_0_101_1111, // R3 relock, hold
    11'b01_1_0_001_0101, // R3 loss with lo -> 0
    11'b01_1_0_110_0101, // R2 hold
    11'b01_1_0_010_1111, // R2 loss with hi -> 1
    11'b01_0_0_100_0011, // R4 pin disabled, bit still 1
    11'b01_1_0_000_0101, // R3 loss with neither -> 0
    11'b00_0_0_100_0011, // R4 lock mode, pin disabled
    11'b00_1_1_100_1110, // R5 loop off
    11'b10_1_0_100_0001, // R6 reserved 10
    11'b11_1_1_100_0000, // R6 reserved 11
    11'b00_1_0_000_0101  // R1 reference lost -> unlocked
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [10:0] v);
    if (v[10])      return "R6";
    else if (v[7])  return "R5";
    else if (!v[8]) return "R4";
    else if (v[9])  return "R2 R3";
    else            return "R1";
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 values held in reset
    check("R8 reset bit", status_bit, 1'b0);
    check("R8 reset oe", status_pin_oe, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 unlocked after reset", status_bit, 1'b0);
    mode_sel = 2'b01;
    @(negedge clk);
    check("R8 dir zero after reset", status_bit, 1'b0);
    check("R5 pump on", pump_en, 1'b1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      mode_sel    = v[10:9];
      pin_en      = v[8];
      loop_off    = v[7];
      lock_in     = v[6];
      range_hi_in = v[5];
      range_lo_in = v[4];
      repeat (4) @(negedge clk);
      check({tag_of(v), " pin"},  status_pin,    v[3]);
      check({tag_of(v), " oe"},   status_pin_oe, v[2]);
      check({tag_of(v), " bit"},  status_bit,    v[1]);
      check({tag_of(v), " pump"}, pump_en,       v[0]);
    end

    // R7 exact latency: lock is 0 here, lock mode
    mode_sel = 2'b00; pin_en = 1'b1; loop_off = 1'b0;
    lock_in = 1'b1;
    @(negedge clk);
    check("R7 one edge not visible", status_bit, 1'b0);
    @(negedge clk);
    check("R7 two edges visible", status_bit, 1'b1);
    check("R7 pin follows", status_pin, 1'b1);
    lock_in = 1'b0;
    @(negedge clk);
    check("R7 fall one edge", status_bit, 1'b1);
    @(negedge clk);
    check("R7 fall two edges", status_bit, 1'b0);

    // R8 reset while direction is 1 and locked
    mode_sel = 2'b01;
    range_hi_in = 1'b1; lock_in = 1'b1;
    repeat (4) @(negedge clk);
    lock_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 dir set before reset", status_bit, 1'b1);
    lock_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 dir cleared in reset", status_bit, 1'b0);
    mode_sel = 2'b00;
    @(negedge clk);
    check("R8 lock cleared in reset", status_bit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 unlocked one edge after release", status_bit, 1'b0);
    @(negedge clk);
    check("R8 locked after sync", status_bit, 1'b1);
    mode_sel = 2'b01;
    @(negedge clk);
    check("R8 dir still zero", status_bit, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule